// File: doc/BRIEF.md
# Dispatch Group Slot Accounting Unit

This unit keeps the running slot budget of the dispatch group that an in-order issue stage is currently building. Each cycle at most one classified instruction is offered, with a 5-bit class code, a branch flag, a record-form flag and a valid strobe. The unit works out the instruction's slot cost and decides whether it has to lead a fresh group. It then either adds the cost to the running total or closes the group.

The unit also serves padding. When the surrounding logic flags a load-after-store hazard, the unit reports how many no-op slots must be inserted to push the load into the next group. If a no-op insert strobe arrives, it books the inserted no-op against the group. In the terminating no-op mode, a single no-op ends the group.

The group is tracked by a small state machine whose states follow the slot register. GRP_EMPTY means no slots are used. GRP_OPEN means 1 to 4 slots are used. GRP_FULL means 5 or more slots are used. Its named transitions are:
- open: GRP_EMPTY to GRP_OPEN when the first instruction is added.
- fill: GRP_OPEN to GRP_FULL when the count reaches 5 or more.
- close-full: GRP_FULL to GRP_EMPTY when an instruction arrives at exactly 5 slots.
- close-branch: any state to GRP_EMPTY when a second branch arrives.
- restart: the group is dropped for a must-lead instruction and reopened with that instruction's cost.
- pad: no-op counted, count plus 1.
- pad-close: no-op ends the group.
- clear: synchronous reset or the clear input.

Top module: `dgs_slot_acct`

## Requirements
- R1: While `rst_n` is low, or on a cycle with `clr` high, the slot count and branch count become 0 at the next edge; `clr` overrides every other input that cycle.
- R2: Slot cost by class code: 1 (divide) and 2 (update-form load/store) cost 2; 3 (indexed update), 4 (reserve / conditional store) and 5 (move to condition register) cost 4; 0 (plain), 6 (condition-register logical), 7 (read condition register), 8 (write special register) and all codes 9 to 31 cost 1. From an empty group, an accepted instruction leaves the slot count equal to its cost.
- R3: A record-form instruction whose class costs 1 costs 2 instead; record form does not change a class that costs 2 or 4.
- R4: `must_first` is high exactly when `in_valid` is high and the instruction costs more than 1 slot (after R3) or has class code 6, 7 or 8.
- R5: A must-lead instruction arriving with a nonzero slot count, and not closing the group by R6 or R7, drops the group first. The slot count then becomes its cost, and the branch count becomes its branch flag.
- R6: A valid instruction that meets a slot count of exactly 5 clears slots and branches to 0 and is not counted.
- R7: A valid branch that meets a branch count of 1 clears slots and branches to 0 and is not counted.
- R8: Otherwise a valid instruction adds its cost to the slot count and its branch flag to the branch count.
- R9: With `las_hazard` high and the slot count below 6, `nop_count` is 1 in terminating mode (`term_nop_mode` high) and 5 minus the slot count otherwise. It is 0 when there is no hazard or the count is 6 or more.
- R10: `nop_hazard` is high exactly when `las_hazard` and `first_query` are both high.
- R11: A no-op insert clears the group when terminating mode is on or the slot count is 6; otherwise it adds 1 to the slot count.
- R12: When a no-op insert and a valid instruction share a cycle, the no-op is applied first and the instruction is judged against the resulting count.
- R13: The slot count saturates at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous group clear |
| in_valid | input | 1 | Instruction offered this cycle |
| in_class | input | 5 | Instruction class code |
| in_branch | input | 1 | Instruction is a branch |
| in_record | input | 1 | Instruction is a record (condition-setting) form |
| nop_insert | input | 1 | A no-op is inserted this cycle |
| term_nop_mode | input | 1 | A single no-op terminates the group |
| las_hazard | input | 1 | Load-after-store hazard flagged for the candidate |
| first_query | input | 1 | First hazard query of the cycle |
| slot_count | output | 3 | Slots used by the current group |
| branch_count | output | 2 | Branches in the current group |
| must_first | output | 1 | Offered instruction must lead its group |
| nop_count | output | 3 | No-op slots required for the hazard |
| nop_hazard | output | 1 | Hazard query asks for no-ops |

## Verification
A no-op insert and an accepted instruction can land in the same cycle. The no-op must be applied before the instruction, so the two orders give different counts. The bench provokes this at a slot count of 5, where the no-op moves the group to 6, so the instruction is added and the count reaches 7 instead of the group closing. It also provokes it at a count of 6, where the no-op closes the group and a branch then opens a fresh one. Its scoreboard predicts the post-edge slot and branch counts from the requirement order and flags either ordering mistake.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

    localparam int CLASS_W = 5;

    // Class codes that carry special cost or placement rules.
    localparam logic [CLASS_W-1:0] CLS_PLAIN     = 5'd0;
    localparam logic [CLASS_W-1:0] CLS_DIVIDE    = 5'd1;
    localparam logic [CLASS_W-1:0] CLS_UPD       = 5'd2;
    localparam logic [CLASS_W-1:0] CLS_UPD_IDX   = 5'd3;
    localparam logic [CLASS_W-1:0] CLS_RESERVE   = 5'd4;
    localparam logic [CLASS_W-1:0] CLS_MOVE_CR   = 5'd5;
    localparam logic [CLASS_W-1:0] CLS_CR_LOGIC  = 5'd6;
    localparam logic [CLASS_W-1:0] CLS_READ_CR   = 5'd7;
    localparam logic [CLASS_W-1:0] CLS_WRITE_SPR = 5'd8;

    typedef enum logic [1:0] {
        GRP_EMPTY = 2'd0,
        GRP_OPEN  = 2'd1,
        GRP_FULL  = 2'd2
    } grp_state_e;

endpackage

// File: rtl/dgs_classify.sv
module dgs_classify
    import dgs_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic               record,
    output logic [SLOT_W-1:0]  cost,
    output logic               lead
);

    logic [SLOT_W-1:0] base_cost;
    logic              placed_first;

    always_comb begin
        unique case (cls)
            CLS_DIVIDE, CLS_UPD:                  base_cost = SLOT_W'(2);
            CLS_UPD_IDX, CLS_RESERVE, CLS_MOVE_CR: base_cost = SLOT_W'(4);
            default:                              base_cost = SLOT_W'(1);
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_CR_LOGIC, CLS_READ_CR, CLS_WRITE_SPR: placed_first = 1'b1;
            default:                                  placed_first = 1'b0;
        endcase
    end

    // Record forms of single-slot classes take a second slot.
    assign cost = (base_cost == SLOT_W'(1) && record) ? SLOT_W'(2) : base_cost;
    assign lead = (cost > SLOT_W'(1)) || placed_first;

endmodule

// File: rtl/dgs_nop_calc.sv
module dgs_nop_calc #(
    parameter int SLOT_W      = 3,
    parameter int FILL_SLOTS  = 5,
    parameter int PAD_LIMIT   = 6
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              hazard,
    input  logic              stall0,
    input  logic              term_mode,
    output logic [SLOT_W-1:0] nop_count,
    output logic              hazard_req
);

    always_comb begin
        nop_count = '0;
        if (hazard && slot < SLOT_W'(PAD_LIMIT)) begin
            if (term_mode)
                nop_count = SLOT_W'(1);
            else if (slot <= SLOT_W'(FILL_SLOTS))
                nop_count = SLOT_W'(FILL_SLOTS) - slot;
        end
    end

    assign hazard_req = hazard && stall0;

endmodule

// File: rtl/dgs_group_fsm.sv
module dgs_group_fsm
    import dgs_pkg::*;
#(
    parameter int SLOT_W     = 3,
    parameter int BR_W       = 2,
    parameter int FILL_SLOTS = 5,
    parameter int PAD_LIMIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              valid,
    input  logic              branch,
    input  logic [SLOT_W-1:0] cost,
    input  logic              lead,
    input  logic              nop_insert,
    input  logic              term_mode,
    output logic [SLOT_W-1:0] slot_q,
    output logic [BR_W-1:0]   br_q
);

    localparam int SLOT_MAX = (1 << SLOT_W) - 1;

    grp_state_e        state_q, state_d;
    logic [SLOT_W-1:0] pad_slot, base_slot, slot_d;
    logic [BR_W-1:0]   pad_br, base_br, br_d;
    logic [SLOT_W:0]   sum;

    // Next group contents: padding first, then the offered instruction.
    always_comb begin
        pad_slot = slot_q;
        pad_br   = br_q;
        if (nop_insert) begin
            if (term_mode || slot_q == SLOT_W'(PAD_LIMIT)) begin
                pad_slot = '0;
                pad_br   = '0;
            end else if (slot_q != SLOT_W'(SLOT_MAX)) begin
                pad_slot = slot_q + 1'b1;
            end
        end

        slot_d    = pad_slot;
        br_d      = pad_br;
        base_slot = pad_slot;
        base_br   = pad_br;
        sum       = '0;
        if (valid) begin
            if (pad_slot == SLOT_W'(FILL_SLOTS) ||
                (branch && pad_br == BR_W'(1))) begin
                slot_d = '0;
                br_d   = '0;
            end else begin
                if (lead && pad_slot != '0) begin
                    base_slot = '0;
                    base_br   = '0;
                end
                sum    = {1'b0, base_slot} + {1'b0, cost};
                slot_d = (sum > (SLOT_W+1)'(SLOT_MAX)) ? SLOT_W'(SLOT_MAX)
                                                       : sum[SLOT_W-1:0];
                br_d   = base_br + BR_W'(branch);
            end
        end

        if (clr) begin
            slot_d = '0;
            br_d   = '0;
        end
    end

    // State follows the next slot count.
    always_comb begin
        unique case (1'b1)
            (slot_d == '0):                      state_d = GRP_EMPTY;
            (slot_d >= SLOT_W'(FILL_SLOTS)):     state_d = GRP_FULL;
            default:                             state_d = GRP_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GRP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            br_q   <= '0;
        end else begin
            slot_q <= slot_d;
            br_q   <= br_d;
        end
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (slot_q == '0 && br_q == '0));

    assert_full_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr && !nop_insert && slot_q == SLOT_W'(FILL_SLOTS))
        |=> (slot_q == '0 && br_q == '0));

    assert_one_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_q <= BR_W'(1));

    assert_state_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_EMPTY) == (slot_q == '0));

    assert_pad_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_insert && term_mode && !valid && !clr) |=> (slot_q == '0));

    assert_saturate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_W'(SLOT_MAX) && valid && !clr && !nop_insert && !lead &&
         !(branch && br_q == BR_W'(1))) |=> (slot_q == SLOT_W'(SLOT_MAX)));

endmodule

// File: rtl/dgs_slot_acct.sv
module dgs_slot_acct
    import dgs_pkg::*;
#(
    parameter int SLOT_W     = 3,
    parameter int BR_W       = 2,
    parameter int FILL_SLOTS = 5,
    parameter int PAD_LIMIT  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               in_valid,
    input  logic [CLASS_W-1:0] in_class,
    input  logic               in_branch,
    input  logic               in_record,
    input  logic               nop_insert,
    input  logic               term_nop_mode,
    input  logic               las_hazard,
    input  logic               first_query,
    output logic [SLOT_W-1:0]  slot_count,
    output logic [BR_W-1:0]    branch_count,
    output logic               must_first,
    output logic [SLOT_W-1:0]  nop_count,
    output logic               nop_hazard
);

    logic [SLOT_W-1:0] cost;
    logic              lead;

    dgs_classify #(.SLOT_W(SLOT_W)) u_classify (
        .cls    (in_class),
        .record (in_record),
        .cost   (cost),
        .lead   (lead)
    );

    dgs_group_fsm #(
        .SLOT_W     (SLOT_W),
        .BR_W       (BR_W),
        .FILL_SLOTS (FILL_SLOTS),
        .PAD_LIMIT  (PAD_LIMIT)
    ) u_group (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .valid      (in_valid),
        .branch     (in_branch),
        .cost       (cost),
        .lead       (lead),
        .nop_insert (nop_insert),
        .term_mode  (term_nop_mode),
        .slot_q     (slot_count),
        .br_q       (branch_count)
    );

    dgs_nop_calc #(
        .SLOT_W     (SLOT_W),
        .FILL_SLOTS (FILL_SLOTS),
        .PAD_LIMIT  (PAD_LIMIT)
    ) u_nop (
        .slot       (slot_count),
        .hazard     (las_hazard),
        .stall0     (first_query),
        .term_mode  (term_nop_mode),
        .nop_count  (nop_count),
        .hazard_req (nop_hazard)
    );

    assign must_first = in_valid && lead;

    assert_nop_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nop_count <= SLOT_W'(FILL_SLOTS));

    assert_query_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nop_hazard |-> (las_hazard && first_query));

    assert_lead_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (must_first && !clr && !nop_insert && slot_count != '0 &&
         slot_count != SLOT_W'(FILL_SLOTS) && !(in_branch && branch_count == BR_W'(1)))
        |=> (slot_count != '0 && branch_count == BR_W'($past(in_branch))));

endmodule

// File: tb/dgs_slot_acct_test.sv
module dgs_slot_acct_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] in_class = '0;
    logic       in_branch = 1'b0;
    logic       in_record = 1'b0;
    logic       nop_insert = 1'b0;
    logic       term_nop_mode = 1'b0;
    logic       las_hazard = 1'b0;
    logic       first_query = 1'b0;
    logic [2:0] slot_count;
    logic [1:0] branch_count;
    logic       must_first;
    logic [2:0] nop_count;
    logic       nop_hazard;

    int n_checks = 0;
    int n_fail = 0;
    int m_slot = 0;
    int m_br = 0;
    bit done = 1'b0;

    int    q_slot[$];
    int    q_br[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dgs_slot_acct uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_class(in_class), .in_branch(in_branch), .in_record(in_record),
        .nop_insert(nop_insert), .term_nop_mode(term_nop_mode),
        .las_hazard(las_hazard), .first_query(first_query),
        .slot_count(slot_count), .branch_count(branch_count),
        .must_first(must_first), .nop_count(nop_count), .nop_hazard(nop_hazard)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cost_of(input int c, input bit r);
        int k;
        case (c)
            1, 2:    k = 2;
            3, 4, 5: k = 4;
            default: k = 1;
        endcase
        if (k == 1 && r) k = 2;
        return k;
    endfunction

    function automatic bit first_of(input int c, input bit r);
        return cost_of(c, r) > 1 || c == 6 || c == 7 || c == 8;
    endfunction

    // Driver: model the requirement order, drive, push the expectation.
    task automatic step(input bit v, input int c, input bit b, input bit r,
                        input bit ni, input bit mode, input bit cl, input string tag);
        if (cl) begin
            m_slot = 0; m_br = 0;
        end else begin
            if (ni) begin
                if (mode || m_slot == 6) begin m_slot = 0; m_br = 0; end
                else if (m_slot < 7) m_slot++;
            end
            if (v) begin
                if (m_slot == 5 || (b && m_br == 1)) begin
                    m_slot = 0; m_br = 0;
                end else begin
                    if (first_of(c, r) && m_slot != 0) begin m_slot = 0; m_br = 0; end
                    m_slot = m_slot + cost_of(c, r);
                    if (m_slot > 7) m_slot = 7;
                    m_br = m_br + int'(b);
                end
            end
        end
        @(negedge clk);
        in_valid = v; in_class = 5'(c); in_branch = b; in_record = r;
        nop_insert = ni; term_nop_mode = mode; clr = cl;
        las_hazard = 1'b0; first_query = 1'b0;
        q_slot.push_back(m_slot);
        q_br.push_back(m_br);
        q_tag.push_back(tag);
        #1;
        chk("R4 must_first", int'(must_first), int'(v && first_of(c, r)));
    endtask

    task automatic plain(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wipe();
        step(0, 0, 0, 0, 0, 0, 1, "R1");
    endtask

    // Combinational hazard probe on the current group state.
    task automatic probe(input bit haz, input bit q, input bit mode);
        int exp_n;
        @(negedge clk);
        in_valid = 1'b0; nop_insert = 1'b0; clr = 1'b0;
        las_hazard = haz; first_query = q; term_nop_mode = mode;
        #1;
        exp_n = 0;
        if (haz && m_slot < 6) exp_n = mode ? 1 : 5 - m_slot;
        chk("R9 nop_count", int'(nop_count), exp_n);
        chk("R10 nop_hazard", int'(nop_hazard), int'(haz && q));
    endtask

    // Monitor: compare registered counts just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_slot.size() > 0) begin
                int es, eb;
                string t;
                es = q_slot.pop_front();
                eb = q_br.pop_front();
                t  = q_tag.pop_front();
                chk({t, " slot_count"}, int'(slot_count), es);
                chk({t, " branch_count"}, int'(branch_count), eb);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset slot", int'(slot_count), 0);
        chk("R1 reset branch", int'(branch_count), 0);
        rst_n = 1'b1;

        // R2: cost per class from an empty group
        for (int c = 0; c < 10; c++) begin
            wipe();
            step(1, c, 0, 0, 0, 0, 0, "R2");
        end
        // R3: record promotion
        wipe(); step(1, 0, 0, 1, 0, 0, 0, "R3");
        wipe(); step(1, 2, 0, 1, 0, 0, 0, "R3");
        wipe(); step(1, 4, 0, 1, 0, 0, 0, "R3");
        step(0, 1, 0, 1, 0, 0, 0, "R4");

        // R8 accumulation then R6 close on full
        wipe(); plain(4, "R8");
        step(1, 0, 1, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 0, "R6");

        // R7 second branch
        wipe();
        step(1, 0, 1, 0, 0, 0, 0, "R7");
        plain(1, "R7");
        step(1, 0, 1, 0, 0, 0, 0, "R7");

        // R5 must-lead in a partial group
        wipe(); plain(2, "R5");
        step(1, 1, 0, 0, 0, 0, 0, "R5");
        plain(1, "R5");
        step(1, 6, 0, 0, 0, 0, 0, "R5");
        plain(1, "R5");
        step(1, 8, 1, 0, 0, 0, 0, "R5");

        // R9 / R10 padding demand at every count 0..5
        for (int s = 0; s < 6; s++) begin
            wipe(); plain(s, "R9");
            probe(1, 1, 0);
            probe(1, 1, 1);
            probe(1, 0, 0);
            probe(0, 1, 0);
        end
        // count 6 via padding, then no demand
        step(0, 0, 0, 0, 1, 0, 0, "R11");
        probe(1, 1, 0);
        probe(1, 1, 1);
        step(0, 0, 0, 0, 1, 0, 0, "R11");
        wipe(); plain(3, "R11");
        step(0, 0, 0, 0, 1, 1, 0, "R11");
        plain(2, "R11");
        step(0, 0, 0, 0, 1, 0, 0, "R11");

        // R12 no-op and instruction together, then R13 saturation
        wipe(); plain(5, "R12");
        step(1, 0, 0, 0, 1, 0, 0, "R12");
        step(1, 0, 0, 0, 0, 0, 0, "R13");
        step(0, 0, 0, 0, 1, 0, 0, "R13");
        wipe(); plain(5, "R12");
        step(0, 0, 0, 0, 1, 0, 0, "R12");
        step(1, 0, 1, 0, 1, 0, 0, "R12");

        // R1 clear beats an offered instruction
        plain(1, "R1");
        step(1, 3, 1, 0, 0, 0, 1, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule